// File: doc/BRIEF.md
# Buffered SPI Client Transmitter

This block is the data path of an 8-bit SPI client. Software hands bytes to it through a single write port. The SPI host drives the serial clock, the select line and the host-to-client data line. The block samples all three in its own system clock domain, shifts the received bits into a shift register, and returns the outgoing bits on the client-to-host line. One holding buffer sits in front of the shift register. Software can therefore queue the next byte while the current one is still on the wire. Three status flags tell software when to write and when a byte has arrived:

- data-register-empty: the holding buffer can take a byte.
- receive-complete: a byte has been received.
- transfer-complete: everything queued has gone out.

Two control inputs shape the behaviour. A buffer-enable input chooses between direct loading of the shift register and buffered operation. In buffered operation, a wait-for-receive input decides how the first byte of a select session is handled:

- Cleared: the first transfer sends whatever the shift register already holds, as a dummy byte, before any user data.
- Set: a byte written while the select line is idle goes straight into the shift register, so user data leaves on the very first transfer.

The shift register takes in the received bits. The dummy byte is therefore the byte last received, or zero after reset.

Top module: `spi_buf_client`

## Requirements
- R1: After reset, data-register-empty is 1, receive-complete and transfer-complete are 0, the output enable is 0, the received-byte register is 0x00 and the shift register is 0x00.
- R2: With buffering enabled, a write accepted into the holding buffer drives data-register-empty low from the next clock.
- R3: A buffered write made while data-register-empty is low leaves the holding buffer unchanged, so that byte is never transmitted.
- R4: At the end of each transfer, a byte waiting in the holding buffer moves into the shift register and is the next byte sent. Data-register-empty rises on the clock after the end of the transfer.
- R5: With wait-for-receive cleared, a transfer starting with nothing newly loaded sends the current shift register contents. These are the byte received in the previous transfer, or 0x00 after reset.
- R6: With buffering enabled and wait-for-receive set, the first write while select is high goes to the shift register on the next clock and leaves data-register-empty high. Further writes go to the holding buffer until select rises again at the end of a session.
- R7: Receive-complete is set two clocks after the end of every transfer, which is one clock after data-register-empty rises when a buffered byte was handed over.
- R8: Transfer-complete is set one clock after receive-complete, only when the holding buffer was empty at the end of the transfer.
- R9: Transfers use SPI mode 0, 8 bits, most significant bit first. Output bits are valid at each rising serial clock edge. The received byte is latched into the received-byte register at the end of the transfer.
- R10: The output enable follows the synchronized select line: 0 while select is high, 1 while it is low.
- R11: A pulse on the flag-clear input clears receive-complete with bit 0 and transfer-complete with bit 1. A set in the same clock wins.
- R12: With buffering disabled, a write loads the shift register on the next clock and data-register-empty stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_en | input | 1 | 1 selects buffered operation |
| wait_rx | input | 1 | Wait-for-receive mode for buffered operation |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 8 | Data to transmit |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 receive-complete, bit 1 transfer-complete |
| sck | input | 1 | Serial clock from host, asynchronous |
| ss_n | input | 1 | Active-low select from host, asynchronous |
| mosi | input | 1 | Serial data from host, asynchronous |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for miso, 0 means high impedance |
| rx_data | output | 8 | Last received byte |
| dre_flag | output | 1 | Holding buffer empty |
| rxc_flag | output | 1 | Receive complete, sticky |
| txc_flag | output | 1 | Transfer complete, sticky |

## Verification
A software write can land in the same system clock as the end-of-transfer hand-off. The bench provokes this by raising the eighth serial clock edge and then asserting the write exactly two clocks later, which is the clock in which the synchronized edge completes the byte. Two outcomes are judged from the bytes seen on miso in the following transfers:

- When the buffer was full, the hand-off wins and the new byte is lost.
- When the buffer was empty, the write is kept. It is sent only after one more transfer of the freshly received byte.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;

  localparam int FLG_RXC = 0;
  localparam int FLG_TXC = 1;

  typedef struct packed {
    logic sck_rise;
    logic sck_fall;
    logic ss_act;
    logic ss_end;
    logic mosi;
  } spi_evt_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
  import spi_buf_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sck,
  input  logic     ss_n,
  input  logic     mosi,
  output spi_evt_t evt
);

  localparam logic [2:0] IDLE_VAL = 3'b010;

  logic [2:0] chain [STAGES];
  logic [2:0] last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= IDLE_VAL;
          else        chain[g] <= {sck, ss_n, mosi};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= IDLE_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDLE_VAL;
    else        last_q <= chain[STAGES-1];
  end

  always_comb begin
    evt.sck_rise = chain[STAGES-1][2] & ~last_q[2];
    evt.sck_fall = ~chain[STAGES-1][2] & last_q[2];
    evt.ss_act   = ~chain[STAGES-1][1];
    evt.ss_end   = chain[STAGES-1][1] & ~last_q[1];
    evt.mosi     = chain[STAGES-1][0];
  end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_buf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  spi_evt_t      evt,
  input  logic          load_en,
  input  logic [DW-1:0] load_data,
  output logic          sh_msb,
  output logic          xfer_done,
  output logic [DW-1:0] rx_byte
);

  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic [DW-1:0] sh_q;
  logic [CW-1:0] bit_q;
  logic          lat_q;

  function automatic logic [DW-1:0] push_bit(input logic [DW-1:0] v, input logic b);
    return {v[DW-2:0], b};
  endfunction

  assign xfer_done = evt.ss_act && evt.sck_rise && (bit_q == LAST_BIT);
  assign rx_byte   = push_bit(sh_q, evt.mosi);
  assign sh_msb    = sh_q[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      lat_q <= 1'b0;
    end else if (!evt.ss_act) begin
      bit_q <= '0;
    end else if (evt.sck_rise) begin
      lat_q <= evt.mosi;
      bit_q <= (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sh_q <= '0;
    else if (load_en)
      sh_q <= load_data;
    else if (evt.ss_act && evt.sck_fall && bit_q != '0)
      sh_q <= push_bit(sh_q, lat_q);
  end

endmodule

// File: rtl/spi_txbuf_ctrl.sv
module spi_txbuf_ctrl
  import spi_buf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_en,
  input  logic          wait_rx,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    flag_clr,
  input  logic          ss_act,
  input  logic          ss_end,
  input  logic          xfer_done,
  input  logic [DW-1:0] rx_byte,
  output logic          load_en,
  output logic [DW-1:0] load_data,
  output logic [DW-1:0] hold_q,
  output logic [DW-1:0] rx_data,
  output logic          dre_flag,
  output logic          rxc_flag,
  output logic          txc_flag,
  output logic          rxc_set,
  output logic          txc_set,
  output logic          drop_wr
);

  logic full_q, claimed_q;
  logic done_d1, done_d2, empty_d1, empty_d2;
  logic direct_wr, hold_wr;

  assign direct_wr = wr_en && (!buf_en || (wait_rx && !ss_act && !claimed_q));
  assign hold_wr   = wr_en && buf_en && !direct_wr && !full_q;
  assign drop_wr   = wr_en && buf_en && !direct_wr && full_q;

  assign load_en   = xfer_done || direct_wr;
  assign load_data = xfer_done ? (full_q ? hold_q : rx_byte) : wr_data;

  assign dre_flag  = ~full_q;
  assign rxc_set   = done_d1;
  assign txc_set   = done_d2 && empty_d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (hold_wr) begin
      hold_q <= wr_data;
      full_q <= 1'b1;
    end else if (xfer_done && full_q) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  claimed_q <= 1'b0;
    else if (ss_end)             claimed_q <= 1'b0;
    else if (direct_wr && buf_en) claimed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_d1  <= 1'b0;
      done_d2  <= 1'b0;
      empty_d1 <= 1'b0;
      empty_d2 <= 1'b0;
      rx_data  <= '0;
    end else begin
      done_d1  <= xfer_done;
      done_d2  <= done_d1;
      empty_d1 <= xfer_done && !full_q;
      empty_d2 <= empty_d1;
      if (xfer_done) rx_data <= rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxc_flag <= 1'b0;
      txc_flag <= 1'b0;
    end else begin
      if (rxc_set)                rxc_flag <= 1'b1;
      else if (flag_clr[FLG_RXC]) rxc_flag <= 1'b0;
      if (txc_set)                txc_flag <= 1'b1;
      else if (flag_clr[FLG_TXC]) txc_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_buf_client.sv
module spi_buf_client
  import spi_buf_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_en,
  input  logic          wait_rx,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    flag_clr,
  input  logic          sck,
  input  logic          ss_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic [DW-1:0] rx_data,
  output logic          dre_flag,
  output logic          rxc_flag,
  output logic          txc_flag
);

  spi_evt_t      evt;
  logic          load_en, xfer_done, sh_msb;
  logic [DW-1:0] load_data, rx_byte, hold_q;
  logic          rxc_set, txc_set, drop_wr;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi), .evt(evt)
  );

  spi_shift_core #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .evt(evt), .load_en(load_en),
    .load_data(load_data), .sh_msb(sh_msb), .xfer_done(xfer_done),
    .rx_byte(rx_byte)
  );

  spi_txbuf_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .wait_rx(wait_rx),
    .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr),
    .ss_act(evt.ss_act), .ss_end(evt.ss_end), .xfer_done(xfer_done),
    .rx_byte(rx_byte), .load_en(load_en), .load_data(load_data),
    .hold_q(hold_q), .rx_data(rx_data), .dre_flag(dre_flag),
    .rxc_flag(rxc_flag), .txc_flag(txc_flag), .rxc_set(rxc_set),
    .txc_set(txc_set), .drop_wr(drop_wr)
  );

  assign miso    = sh_msb;
  assign miso_oe = evt.ss_act;

endmodule

// File: rtl/spi_buf_client_chk.sv
module spi_buf_client_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          drop_wr,
  input logic          wr_en,
  input logic          dre_flag,
  input logic          rxc_flag,
  input logic [DW-1:0] hold_q,
  input logic          rxc_set,
  input logic          txc_set,
  input logic          xfer_done,
  input logic          miso_oe
);

  assert_no_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_wr |=> $stable(hold_q));

  assert_rxc_after_dre_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dre_flag) |=> rxc_flag);

  assert_txc_after_rxc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txc_set |-> $past(rxc_set));

  assert_dre_fall_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dre_flag) |-> $past(wr_en));

  assert_done_only_selected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> miso_oe);

endmodule

bind spi_buf_client spi_buf_client_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .drop_wr(drop_wr), .wr_en(wr_en),
  .dre_flag(dre_flag), .rxc_flag(rxc_flag), .hold_q(hold_q),
  .rxc_set(rxc_set), .txc_set(txc_set), .xfer_done(xfer_done),
  .miso_oe(miso_oe)
);

// File: tb/tb_spi_buf_client.sv
module tb_spi_buf_client;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       buf_en = 1'b0, wait_rx = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] flag_clr = 2'b00;
  logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic       miso, miso_oe, dre_flag, rxc_flag, txc_flag;
  logic [7:0] rx_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int t_dre = -1, t_rxc = -1, t_txc = -1;
  logic p_dre = 1'b1, p_rxc = 1'b0, p_txc = 1'b0;

  always #10 clk = ~clk;

  spi_buf_client dut (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .wait_rx(wait_rx),
    .wr_en(wr_en), .wr_data(wr_data), .flag_clr(flag_clr), .sck(sck),
    .ss_n(ss_n), .mosi(mosi), .miso(miso), .miso_oe(miso_oe),
    .rx_data(rx_data), .dre_flag(dre_flag), .rxc_flag(rxc_flag),
    .txc_flag(txc_flag)
  );

  always @(negedge clk) begin
    cyc++;
    if (dre_flag && !p_dre) t_dre = cyc;
    if (rxc_flag && !p_rxc) t_rxc = cyc;
    if (txc_flag && !p_txc) t_txc = cyc;
    p_dre = dre_flag; p_rxc = rxc_flag; p_txc = txc_flag;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic clr(input logic [1:0] b);
    @(negedge clk); flag_clr = b;
    @(negedge clk); flag_clr = 2'b00;
  endtask

  task automatic sel(input logic lvl);
    @(negedge clk); ss_n = lvl;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic marks_reset();
    t_dre = -1; t_rxc = -1; t_txc = -1;
  endtask

  // col=1: write cd in the clock where the eighth edge completes the byte
  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi,
                      input logic col, input logic [7:0] cd);
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk); mosi = mo[b];
      repeat (HALF) @(negedge clk);
      mi[b] = miso;
      sck = 1'b1;
      if (b == 0 && col) begin
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr_en = 1'b1; wr_data = cd;
        @(negedge clk); wr_en = 1'b0;
        repeat (HALF - 2) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] got;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dre_flag == 1'b1, "R1 dre", dre_flag, 1);
    chk(rxc_flag == 1'b0 && txc_flag == 1'b0, "R1 flags", {rxc_flag, txc_flag}, 0);
    chk(miso_oe == 1'b0, "R1 oe", miso_oe, 0);
    chk(rx_data == 8'h00, "R1 rx", rx_data, 0);

    // R12 unbuffered direct load, R9 mode 0 MSB first, R10 enable
    wr(8'hA5);
    chk(dre_flag == 1'b1, "R12 dre high", dre_flag, 1);
    sel(1'b0);
    chk(miso_oe == 1'b1, "R10 oe low select", miso_oe, 1);
    xfer(8'h3C, got, 1'b0, 8'h00);
    chk(got == 8'hA5, "R12 miso", got, 8'hA5);
    chk(rx_data == 8'h3C, "R9 rx_data", rx_data, 8'h3C);
    sel(1'b1);
    chk(miso_oe == 1'b0, "R10 oe high select", miso_oe, 0);

    // buffered, wait-for-receive cleared
    buf_en = 1'b1; wait_rx = 1'b0;
    clr(2'b11);
    wr(8'h43);
    chk(dre_flag == 1'b0, "R2 dre low", dre_flag, 0);
    sel(1'b0);
    marks_reset();
    xfer(8'h11, got, 1'b0, 8'h00);
    chk(got == 8'h3C, "R5 dummy is last rx", got, 8'h3C);
    chk(t_rxc - t_dre == 1, "R7 rxc after dre", t_rxc - t_dre, 1);
    chk(txc_flag == 1'b0, "R8 no txc with buffer full", txc_flag, 0);
    chk(dre_flag == 1'b1, "R4 dre high", dre_flag, 1);
    wr(8'h44);
    wr(8'h45);
    xfer(8'h12, got, 1'b0, 8'h00);
    chk(got == 8'h43, "R4 handoff", got, 8'h43);
    clr(2'b11);
    marks_reset();
    xfer(8'h13, got, 1'b0, 8'h00);
    chk(got == 8'h44, "R3 dropped write", got, 8'h44);
    chk(t_txc - t_rxc == 1 && t_rxc > 0, "R8 txc after rxc", t_txc - t_rxc, 1);
    xfer(8'h14, got, 1'b0, 8'h00);
    chk(got == 8'h13, "R5 dummy again", got, 8'h13);
    chk(rx_data == 8'h14, "R9 rx_data", rx_data, 8'h14);
    sel(1'b1);

    // collision: write in the end-of-transfer clock
    wr(8'h50);
    sel(1'b0);
    xfer(8'h21, got, 1'b1, 8'h51);
    chk(got == 8'h14, "R3 collision sent", got, 8'h14);
    xfer(8'h22, got, 1'b0, 8'h00);
    chk(got == 8'h50, "R3 collision full drop", got, 8'h50);
    xfer(8'h23, got, 1'b1, 8'h52);
    chk(got == 8'h22, "R5 collision sent", got, 8'h22);
    chk(dre_flag == 1'b0, "R2 collision kept", dre_flag, 0);
    xfer(8'h24, got, 1'b0, 8'h00);
    chk(got == 8'h23, "R4 collision order", got, 8'h23);
    xfer(8'h25, got, 1'b0, 8'h00);
    chk(got == 8'h52, "R4 collision byte", got, 8'h52);
    sel(1'b1);

    // buffered, wait-for-receive set
    wait_rx = 1'b1;
    wr(8'h43);
    chk(dre_flag == 1'b1, "R6 direct keeps dre", dre_flag, 1);
    wr(8'h44);
    chk(dre_flag == 1'b0, "R6 second to buffer", dre_flag, 0);
    wr(8'h45);
    sel(1'b0);
    xfer(8'h31, got, 1'b0, 8'h00);
    chk(got == 8'h43, "R6 first user byte", got, 8'h43);
    xfer(8'h32, got, 1'b0, 8'h00);
    chk(got == 8'h44, "R3 wait mode drop", got, 8'h44);
    xfer(8'h33, got, 1'b0, 8'h00);
    chk(got == 8'h32, "R5 wait mode dummy", got, 8'h32);
    sel(1'b1);

    // R11 flag clear bits
    clr(2'b01);
    chk(rxc_flag == 1'b0 && txc_flag == 1'b1, "R11 clear rxc", {rxc_flag, txc_flag}, 1);
    clr(2'b10);
    chk(txc_flag == 1'b0, "R11 clear txc", txc_flag, 0);

    // sweep all byte values unbuffered
    buf_en = 1'b0; wait_rx = 1'b0;
    for (int v = 0; v < 256; v++) begin
      wr(8'(v));
      sel(1'b0);
      xfer(~8'(v), got, 1'b0, 8'h00);
      sel(1'b1);
      chk(got == 8'(v), "R9 sweep miso", got, v);
      chk(rx_data == ~8'(v), "R9 sweep rx", rx_data, ~8'(v));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule